// File: doc/BRIEF.md
# SD Native Command-Line Engine

This block runs the command line of an SD card in native mode. A host pulses `start` with a 6-bit command index and a 32-bit argument. The engine generates the SD clock from a programmable divider and leaves at least nine idle clocks on the line. It then shifts out a 48-bit frame that ends with a CRC7 it computes itself, and gives one tail clock before it releases the line. It then waits for the card's start bit, up to a limit set by the host, and captures a response whose length follows from the command index. A stop command (index 12) is followed by a wait on DAT0 busy, and then by four more clocks. When `app_cmd` is set, the engine first sends the application prefix (index 55 carrying the relative card address). It then sends the requested command, without any further action from the host.

The controller is one state machine with these states. `ST_IDLE` goes to `ST_GAP` on start. `ST_GAP` counts nine clocks with the line high, then goes to `ST_SEND`. `ST_SEND` shifts 48 bits, then goes to `ST_TAIL`. `ST_TAIL` gives one clock with the line high and then goes to `ST_WAIT`, or to `ST_DONE` when no response is expected. `ST_WAIT` goes to `ST_RECV` on a start bit, or to `ST_DONE` when the timeout expires. `ST_RECV` collects the response bits. It then goes back to `ST_GAP` after the prefix, to `ST_BUSY` for a stop command, or to `ST_DONE` otherwise. `ST_BUSY` goes to `ST_BTAIL` once DAT0 reads high. `ST_BTAIL` counts four clocks and then goes to `ST_DONE`. `ST_DONE` lasts one cycle and goes back to `ST_IDLE`. The card state machine, changes of clock speed and the data lines are handled elsewhere.

Top module: `sdcmd_engine`

## Requirements
- R1: The first 40 frame bits, sent MSB first, are a 0 start bit, a 1 direction bit, the 6-bit index and then the 32-bit argument, most significant bit first.
- R2: The last frame byte is the CRC7 (polynomial x^7+x^3+1, zero seed) of the first 40 bits, in bits 7:1, with a 1 end bit in bit 0. Index 0 with argument 0 gives 0x95. Index 8 with argument 0x000001AA gives 0x87.
- R3: Before every frame, including the one that follows the application prefix, the line is driven high for exactly 9 SD clock rises.
- R4: After the last frame bit, one more SD clock rise sees the line driven high. The line is released (`cmd_oe`=0) on the falling edge that follows, and stays released while the response arrives. Index 0 releases nothing and finishes at that edge.
- R5: `resp_len` reports the response length in bytes: 0 for index 0, 17 for indices 2, 9 and 10, and 6 for every other index.
- R6: Response bits are sampled on SD clock rises and shifted into `resp_data` MSB first, starting with the start bit. A 48-bit response therefore sits in bits 47:0 with the upper bits zero. The response CRC is not checked.
- R7: If the line stays high for `timeout_limit` consecutive rises after release, the command ends with `timed_out`=1 and `resp_len`=0.
- R8: After the response to index 12, the SD clock keeps running while DAT0 is low. After the rise that first samples DAT0 high, exactly 4 more rises occur before `done`.
- R9: With `app_cmd`=1, index 55 is sent first, with `rca` in argument bits 31:16 and zeros in bits 15:0, and its 48-bit response is received. The requested command is then sent. If the prefix times out, the engine finishes with `timed_out`=1 and sends no second frame.
- R10: The SD clock half-period is `clk_div`+1 system cycles. The command line changes only on falling SD clock edges, and `sd_clk` is held low while the engine is idle.
- R11: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse per command, and `start` has no effect while `busy` is high.
- R12: After reset: `busy`=0, `done`=0, `sd_clk`=0, `cmd_oe`=1, `cmd_out`=1, `timed_out`=0, `resp_len`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (sampled when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| app_cmd | input | 1 | Send the application prefix first |
| rca | input | 16 | Relative card address for the prefix |
| clk_div | input | DIV_W | SD clock half-period minus one, in system cycles |
| timeout_limit | input | TO_W | SD clocks allowed for the response start bit |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_data | output | 136 | Captured response, right-aligned |
| resp_len | output | 5 | Response length in bytes (0, 6 or 17) |
| timed_out | output | 1 | No start bit arrived within the limit |
| sd_clk | output | 1 | Generated SD clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |

## Verification
Assertions check several properties on every cycle. The command line changes only together with a falling SD clock. A release can follow only a tail clock. The clock is parked whenever the engine is idle, `done` never lasts two cycles, and the latched command stays stable while busy. No completion occurs while DAT0 is still low in the busy wait, and a timeout always comes with a zero length. Other properties can only be shown by the bench scenarios, which run a behavioural card against the engine. These are the exact frame bits and CRC bytes, the count of nine idle clocks, the response placement and length for short, long and empty responses, the exact timeout count, the four clocks after busy, and the prefix sequence including its failure path.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_BITS     = 48;
    localparam int SHORT_BITS     = 48;
    localparam int LONG_BITS      = 136;
    localparam int GAP_CLKS       = 9;
    localparam int BUSY_TAIL_CLKS = 4;
    localparam int CNT_W          = $clog2(LONG_BITS + 1);

    localparam logic [5:0] APP_IDX  = 6'd55;
    localparam logic [5:0] STOP_IDX = 6'd12;

    typedef logic [CNT_W-1:0] bitcnt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_SEND,
        ST_TAIL,
        ST_WAIT,
        ST_RECV,
        ST_BUSY,
        ST_BTAIL,
        ST_DONE
    } eng_state_t;

    // CRC7, polynomial x^7 + x^3 + 1, zero seed, data taken MSB first
    function automatic logic [6:0] crc7_calc(input logic [39:0] d);
        logic [6:0] c;
        logic       fb;
        c = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    // number of response bits the card returns for a given index
    function automatic bitcnt_t resp_bits_of(input logic [5:0] idx);
        if (idx == 6'd0)
            return bitcnt_t'(0);
        else if (idx == 6'd2 || idx == 6'd9 || idx == 6'd10)
            return bitcnt_t'(LONG_BITS);
        else
            return bitcnt_t'(SHORT_BITS);
    endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = run && (cnt == div);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R10: a stopped divider parks the clock low
    a_r10_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

endmodule

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
    import sdcmd_pkg::*;
(
    input  logic [5:0]            idx,
    input  logic [31:0]           arg,
    output logic [FRAME_BITS-1:0] frame
);

    logic [39:0] head;
    logic [6:0]  crc;

    assign head  = {2'b01, idx, arg};
    assign crc   = crc7_calc(head);
    assign frame = {head, crc, 1'b1};

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TO_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [5:0]           cmd_index,
    input  logic [31:0]          cmd_arg,
    input  logic                 app_cmd,
    input  logic [15:0]          rca,
    input  logic [DIV_W-1:0]     clk_div,
    input  logic [TO_W-1:0]      timeout_limit,
    output logic                 busy,
    output logic                 done,
    output logic [LONG_BITS-1:0] resp_data,
    output logic [4:0]           resp_len,
    output logic                 timed_out,
    output logic                 sd_clk,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    input  logic                 cmd_in,
    input  logic                 dat0_in
);

    localparam bitcnt_t C_ONE    = bitcnt_t'(1);
    localparam bitcnt_t C_GAP    = bitcnt_t'(GAP_CLKS);
    localparam bitcnt_t C_FRAME  = bitcnt_t'(FRAME_BITS);
    localparam bitcnt_t C_LONG   = bitcnt_t'(LONG_BITS);
    localparam bitcnt_t C_BT_END = bitcnt_t'(BUSY_TAIL_CLKS - 1);

    eng_state_t state, nxt;

    logic                  run, rise_tick, fall_tick;
    bitcnt_t               cnt, rbits;
    logic [TO_W-1:0]       to_cnt;
    logic [TO_W:0]         to_nx;
    logic                  to_hit;
    logic [FRAME_BITS-1:0] frame_sr, frame_w;
    logic [LONG_BITS-1:0]  resp_sr;
    logic [5:0]            cur_idx, sel_idx;
    logic [31:0]           cur_arg, sel_arg;
    logic [15:0]           rca_q;
    logic                  app_pending, is_stop;
    logic [4:0]            resp_len_q;
    logic                  to_q;

    assign sel_idx = app_pending ? APP_IDX : cur_idx;
    assign sel_arg = app_pending ? {rca_q, 16'h0000} : cur_arg;
    assign rbits   = resp_bits_of(sel_idx);
    assign is_stop = (cur_idx == STOP_IDX);
    assign to_nx   = {1'b0, to_cnt} + {{TO_W{1'b0}}, 1'b1};
    assign to_hit  = (to_nx >= {1'b0, timeout_limit});

    sdcmd_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (clk_div),
        .sclk      (sd_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sdcmd_framer u_frm (
        .idx   (sel_idx),
        .arg   (sel_arg),
        .frame (frame_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_GAP;
            ST_GAP:   if (fall_tick && cnt == C_GAP) nxt = ST_SEND;
            ST_SEND:  if (fall_tick && cnt == C_FRAME) nxt = ST_TAIL;
            ST_TAIL:  if (fall_tick && cnt == C_ONE)
                          nxt = (rbits == '0) ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (rise_tick) begin
                          if (!cmd_in)     nxt = ST_RECV;
                          else if (to_hit) nxt = ST_DONE;
                      end
            ST_RECV:  if (rise_tick && (cnt + C_ONE) == rbits) begin
                          if (app_pending)  nxt = ST_GAP;
                          else if (is_stop) nxt = ST_BUSY;
                          else              nxt = ST_DONE;
                      end
            ST_BUSY:  if (rise_tick && dat0_in) nxt = ST_BTAIL;
            ST_BTAIL: if (rise_tick && cnt == C_BT_END) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // counters, shifters and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            to_cnt      <= '0;
            frame_sr    <= '0;
            resp_sr     <= '0;
            cur_idx     <= '0;
            cur_arg     <= '0;
            rca_q       <= '0;
            app_pending <= 1'b0;
            resp_len_q  <= '0;
            to_q        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_idx     <= cmd_index;
                    cur_arg     <= cmd_arg;
                    rca_q       <= rca;
                    app_pending <= app_cmd;
                    cnt         <= '0;
                    resp_sr     <= '0;
                    resp_len_q  <= '0;
                    to_q        <= 1'b0;
                end
                ST_GAP: begin
                    if (rise_tick) cnt <= cnt + C_ONE;
                    if (fall_tick && cnt == C_GAP) begin
                        frame_sr <= frame_w;
                        cnt      <= '0;
                    end
                end
                ST_SEND: begin
                    if (rise_tick) cnt <= cnt + C_ONE;
                    if (fall_tick) begin
                        if (cnt == C_FRAME) cnt <= '0;
                        else                frame_sr <= {frame_sr[FRAME_BITS-2:0], 1'b1};
                    end
                end
                ST_TAIL: begin
                    if (rise_tick) cnt <= cnt + C_ONE;
                    if (fall_tick && cnt == C_ONE) begin
                        cnt     <= '0;
                        to_cnt  <= '0;
                        resp_sr <= '0;
                    end
                end
                ST_WAIT: if (rise_tick) begin
                    if (!cmd_in) begin
                        resp_sr <= {resp_sr[LONG_BITS-2:0], 1'b0};
                        cnt     <= C_ONE;
                    end else begin
                        to_cnt <= to_cnt + 1'b1;
                        if (to_hit) begin
                            to_q       <= 1'b1;
                            resp_len_q <= '0;
                        end
                    end
                end
                ST_RECV: if (rise_tick) begin
                    resp_sr <= {resp_sr[LONG_BITS-2:0], cmd_in};
                    cnt     <= cnt + C_ONE;
                    if ((cnt + C_ONE) == rbits) begin
                        cnt <= '0;
                        if (app_pending) app_pending <= 1'b0;
                        else resp_len_q <= (rbits == C_LONG) ? 5'd17 : 5'd6;
                    end
                end
                ST_BUSY:  if (rise_tick && dat0_in) cnt <= '0;
                ST_BTAIL: if (rise_tick) cnt <= cnt + C_ONE;
                ST_DONE:  ;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        run     = (state != ST_IDLE) && (state != ST_DONE);
        cmd_oe  = !((state == ST_WAIT) || (state == ST_RECV));
        cmd_out = (state == ST_SEND) ? frame_sr[FRAME_BITS-1] : 1'b1;
    end

    assign resp_data = resp_sr;
    assign resp_len  = resp_len_q;
    assign timed_out = to_q;

    // R10: while driven, the command line moves only with a falling SD clock
    a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && $past(cmd_oe) && (cmd_out != $past(cmd_out))) |-> $fell(sd_clk));

    // R10: clock parked whenever idle
    a_r10_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sd_clk);

    // R4: release only at the falling edge closing the tail clock
    a_r4_release_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> ($past(state) == ST_TAIL) && $fell(sd_clk));

    // R11: done lasts exactly one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: latched command held while the engine works
    a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(cur_idx) && $stable(cur_arg)));

    // R8: no completion while the card still holds DAT0 low
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !dat0_in) |=> !done);

    // R7: timeout completes at once with an empty length
    a_r7_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> (done && resp_len == 5'd0));

    // R5: reported lengths are limited to the three legal values
    a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resp_len == 5'd0 || resp_len == 5'd6 || resp_len == 5'd17));

endmodule

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   idx = '0;
    logic [31:0]  arg = '0;
    logic         app = 1'b0;
    logic [15:0]  rca = '0;
    logic [7:0]   div = 8'd1;
    logic [15:0]  tlim = 16'd64;
    logic         card_cmd = 1'b1;
    logic         dat0 = 1'b1;
    logic         busy, done, timed_out, sd_clk, cmd_out, cmd_oe;
    logic [135:0] resp;
    logic [4:0]   rlen;

    sdcmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(idx), .cmd_arg(arg),
        .app_cmd(app), .rca(rca), .clk_div(div), .timeout_limit(tlim),
        .busy(busy), .done(done), .resp_data(resp), .resp_len(rlen),
        .timed_out(timed_out), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_in(card_cmd), .dat0_in(dat0)
    );

    always #2.5 clk = ~clk;

    int  errs = 0, checks = 0, done_seen = 0;
    bit  finished = 0, rose = 0, fell_e = 0;
    logic sd_prev = 1'b0;

    always @(negedge clk) if (done === 1'b1) done_seen++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
        rose   = (sd_clk === 1'b1) && (sd_prev === 1'b0);
        fell_e = (sd_clk === 1'b0) && (sd_prev === 1'b1);
        sd_prev = sd_clk;
    endtask

    task automatic next_rise; do step(); while (!rose); endtask
    task automatic next_fall; do step(); while (!fell_e); endtask

    function automatic logic [7:0] crc_byte(input logic [39:0] h);
        int c = 0;
        for (int i = 39; i >= 0; i--) begin
            int b = h[i] ^ ((c >> 6) & 1);
            c = (c << 1) & 127;
            if (b != 0) c = c ^ 9;
        end
        return 8'((c << 1) | 1);
    endfunction

    function automatic logic [47:0] make_frame(input logic [5:0] i, input logic [31:0] a);
        logic [39:0] h = {2'b01, i, a};
        return {h, crc_byte(h)};
    endfunction

    task automatic pulse_start(input logic [5:0] i, input logic [31:0] a,
                               input logic ap, input logic [15:0] r);
        @(negedge clk);
        idx = i; arg = a; app = ap; rca = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // reference model of the line: 9 high, 48 frame bits, one high tail
    task automatic expect_frame(input logic [5:0] i, input logic [31:0] a,
                                input bit rel, output logic [47:0] got);
        int gap = 0;
        logic [47:0] exp = make_frame(i, a);
        next_rise();
        while (cmd_out === 1'b1 && cmd_oe === 1'b1 && gap < 40) begin
            gap++;
            next_rise();
        end
        check(gap == 9, "R3", "idle rises before frame", gap, 9);
        got[47] = cmd_out;
        for (int b = 46; b >= 0; b--) begin
            next_rise();
            got[b] = cmd_out;
        end
        check(got[47:8] == exp[47:8], "R1", "frame start/index/argument", got[47:8], exp[47:8]);
        check(got[7:0] == exp[7:0], "R2", "frame CRC byte", got[7:0], exp[7:0]);
        next_rise();
        check(cmd_oe === 1'b1 && cmd_out === 1'b1, "R4", "tail clock high", {cmd_oe, cmd_out}, 2'b11);
        if (rel) begin
            next_fall();
            check(cmd_oe === 1'b0, "R4", "line released after tail", cmd_oe, 0);
        end
    endtask

    task automatic card_respond(input logic [135:0] v, input int nbits, input int delay);
        for (int d = 0; d < delay; d++) next_fall();
        for (int b = nbits - 1; b >= 0; b--) begin
            next_fall();
            card_cmd = v[b];
            if (cmd_oe !== 1'b0) check(0, "R4", "released during response", cmd_oe, 0);
        end
        next_fall();
        card_cmd = 1'b1;
    endtask

    task automatic wait_done(input int base, output int rises);
        rises = 0;
        while (done_seen == base) begin
            step();
            if (rose) rises++;
        end
        step();
        step();
        check(done_seen == base + 1, "R11", "single done pulse", done_seen - base, 1);
        check(busy === 1'b0 && sd_clk === 1'b0, "R10", "idle with clock parked", {busy, sd_clk}, 0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] fr;
        int base, r, n;
        logic [47:0]  s48;
        logic [135:0] l136;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        step();
        check(busy === 0 && done === 0 && sd_clk === 0 && cmd_oe === 1 && cmd_out === 1
              && timed_out === 0 && rlen === 0, "R12", "reset state",
              {busy, done, sd_clk, cmd_oe, cmd_out, timed_out, rlen}, 11'b00011000000);

        // index 0: no response, known CRC byte 0x95
        base = done_seen;
        pulse_start(6'd0, 32'h0, 1'b0, 16'h0);
        expect_frame(6'd0, 32'h0, 1'b0, fr);
        check(fr[7:0] == 8'h95, "R2", "index 0 CRC byte", fr[7:0], 8'h95);
        wait_done(base, r);
        check(rlen == 0 && timed_out == 0, "R5", "index 0 has no response", rlen, 0);

        // index 8 with 0x1AA: CRC 0x87, short response with arbitrary CRC
        s48 = 48'h3F12_3456_78AB;
        base = done_seen;
        pulse_start(6'd8, 32'h0000_01AA, 1'b0, 16'h0);
        expect_frame(6'd8, 32'h0000_01AA, 1'b1, fr);
        check(fr[7:0] == 8'h87, "R2", "index 8 CRC byte", fr[7:0], 8'h87);
        card_respond({88'h0, s48}, 48, 3);
        wait_done(base, r);
        check(resp == {88'h0, s48}, "R6", "short response placement", resp, {88'h0, s48});
        check(rlen == 5'd6 && timed_out == 0, "R5", "short length", rlen, 6);

        // index 2: long response; also a stray start while busy (R11)
        l136 = 136'h3F_0123456789ABCDEF_FEDCBA9876543210;
        base = done_seen;
        pulse_start(6'd2, 32'h0, 1'b0, 16'h0);
        fork
            begin
                repeat (20) @(negedge clk);
                idx = 6'd3; arg = 32'hFFFF_FFFF; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join_none
        expect_frame(6'd2, 32'h0, 1'b1, fr);
        check(busy === 1'b1, "R11", "busy during command", busy, 1);
        card_respond(l136, 136, 2);
        wait_done(base, r);
        check(resp == l136, "R6", "long response placement", resp, l136);
        check(rlen == 5'd17, "R5", "long length", rlen, 17);

        // slower divider: period 8 system cycles, half-period 4 (R10)
        div = 8'd3;
        base = done_seen;
        pulse_start(6'd0, 32'h0, 1'b0, 16'h0);
        next_rise();
        n = 0;
        do begin step(); n++; end while (!fell_e);
        check(n == 4, "R10", "half period cycles", n, 4);
        do begin step(); n++; end while (!rose);
        check(n == 8, "R10", "full period cycles", n, 8);
        wait_done(base, r);

        // index 17 at the slower clock
        s48 = 48'h1100_0009_00F1;
        base = done_seen;
        pulse_start(6'd17, 32'hDEAD_BEEF, 1'b0, 16'h0);
        expect_frame(6'd17, 32'hDEAD_BEEF, 1'b1, fr);
        card_respond({88'h0, s48}, 48, 5);
        wait_done(base, r);
        check(resp == {88'h0, s48} && rlen == 5'd6, "R6", "slow-clock response", resp, {88'h0, s48});
        div = 8'd1;

        // timeout after exactly 20 rises
        tlim = 16'd20;
        base = done_seen;
        pulse_start(6'd13, 32'h1234_0000, 1'b0, 16'h0);
        expect_frame(6'd13, 32'h1234_0000, 1'b1, fr);
        wait_done(base, r);
        check(r == 20, "R7", "rises before timeout", r, 20);
        check(timed_out == 1 && rlen == 0, "R7", "timeout flags", {timed_out, rlen}, 6'b100000);
        tlim = 16'd64;

        // stop command: busy wait on DAT0, then 4 more rises
        dat0 = 1'b0;
        s48 = 48'h0C00_0009_0061;
        base = done_seen;
        pulse_start(6'd12, 32'h0, 1'b0, 16'h0);
        expect_frame(6'd12, 32'h0, 1'b1, fr);
        card_respond({88'h0, s48}, 48, 2);
        for (int k = 0; k < 6; k++) next_fall();
        check(busy === 1'b1 && done_seen == base, "R8", "held while DAT0 low", done_seen - base, 0);
        next_fall();
        dat0 = 1'b1;
        wait_done(base, r);
        check(r == 5, "R8", "rises from DAT0 release to done", r, 5);
        check(rlen == 5'd6, "R5", "stop length", rlen, 6);

        // application prefix then index 41
        s48 = 48'h3700_0001_2083;
        base = done_seen;
        pulse_start(6'd41, 32'h40FC_0000, 1'b1, 16'h1234);
        expect_frame(6'd55, 32'h1234_0000, 1'b1, fr);
        check(fr[45:40] == 6'd55, "R9", "prefix index", fr[45:40], 55);
        card_respond({88'h0, s48}, 48, 2);
        s48 = 48'h3F80_FF80_00FF;
        expect_frame(6'd41, 32'h40FC_0000, 1'b1, fr);
        card_respond({88'h0, s48}, 48, 4);
        wait_done(base, r);
        check(resp == {88'h0, s48} && rlen == 5'd6, "R9", "final response after prefix", resp, {88'h0, s48});

        // prefix that times out: no second frame
        tlim = 16'd10;
        base = done_seen;
        pulse_start(6'd41, 32'h0, 1'b1, 16'hBEEF);
        expect_frame(6'd55, 32'hBEEF_0000, 1'b1, fr);
        wait_done(base, r);
        check(r == 10 && timed_out == 1 && rlen == 0, "R9", "prefix timeout ends command",
              {r[7:0], timed_out, rlen}, {8'd10, 1'b1, 5'd0});

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule